// File: doc/BRIEF.md
# Interrupt Trigger Configuration Register Bank

This block is the trigger-configuration part of an interrupt distributor's register space. Every interrupt line has a two-bit field. The upper bit chooses edge-triggered (1) or level-sensitive (0) operation. The lower bit chooses the handling model. Software reaches the fields through byte reads and writes in a fixed window of byte offsets. Each byte holds the fields of four consecutive interrupt IDs. The block drives a per-interrupt edge/level vector to the pending logic that follows it.

The first 16 interrupt IDs are software-generated. They cannot be reconfigured: any write to their bytes has every trigger bit forced to 1, so these lines stay edge-triggered. The private peripheral lines that follow them take whatever trigger mode software writes. A revision parameter decides whether the model bit exists. On the legacy revision the model bit is stored and read back. On later revisions writes to it are dropped and it reads as 0.

A small controller handles each request. It has five states:
- ST_IDLE: no response this cycle.
- ST_RD_OK: read data is valid.
- ST_RD_BAD: a read of an unimplemented byte, which returns zero with the error flag.
- ST_WR_OK: a write was applied.
- ST_WR_BAD: a write to an unimplemented byte was dropped, with the error flag.

From any state, a valid in-window request moves the controller to the state that matches its kind (read or write) and its validity. Any other cycle returns it to ST_IDLE. Requests may therefore arrive back to back.

Top module: `itcfg_bank`

## Requirements
- R1: After reset, IDs 0..15 have edge=1 and model=0, and every other ID has edge=0 and model=0. Reading offsets 0xC00..0xC03 returns 0xAA and reading 0xC04 returns 0x00.
- R2: A byte read at offset o (0xC00 <= o < 0xF00) covers IDs (o-0xC00)*4+BASE_IRQ to that value +3. The lowest ID sits in bits [1:0]. In each field, bit 1 is edge and bit 0 is model. rsp_rd_valid is high for exactly the one cycle after the request cycle.
- R3: A write to a valid byte updates the edge bits of its four IDs. The new values appear on edge_mode in the cycle after the request, and a read returns them.
- R4: In a write to a byte whose IDs are below 16, the written data has all odd bits forced to 1 (data OR 0xAA). Those IDs stay edge-triggered and read back with odd bits set.
- R5: IDs 16 and up accept both edge (1) and level (0) trigger values from software.
- R6: With REVISION = 0 (legacy), the model bits (even bit positions) are stored on write and returned on read.
- R7: With REVISION other than 0, writes to the model bits are ignored and they read as 0. Trigger bits behave as on the legacy revision.
- R8: An in-window access whose first ID is >= NUM_IRQ raises rsp_bad for the one cycle after the request. A read of this kind also raises rsp_rd_valid, with data 0x00. A write of this kind changes nothing.
- R9: Accesses with offset below 0xC00 or at or above 0xF00 produce no rsp_rd_valid and no rsp_bad, and change no field.
- R10: Requests in consecutive cycles are each answered in the cycle after their own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_offset | input | 12 | Byte offset within the distributor space |
| req_wdata | input | 8 | Write data |
| rsp_rd_valid | output | 1 | Read response valid |
| rsp_rd_data | output | 8 | Read response data |
| rsp_bad | output | 1 | Access to an unimplemented byte in the window |
| edge_mode | output | NUM_IRQ | Per-ID trigger mode, 1 = edge, 0 = level |

## Verification
Read data, rsp_rd_valid and rsp_bad come from the controller's state register, so each is due in the cycle that follows the clock edge that accepted the request. edge_mode is written on that same edge and is due in that same following cycle. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It also checks back-to-back requests, an idle cycle after a response to confirm the one-cycle pulse, and the state of a second instance built with a non-legacy revision.

// File: rtl/itcfg_pkg.sv
`timescale 1ns/1ps
package itcfg_pkg;

    localparam logic [11:0] WIN_LO = 12'hC00;
    localparam logic [11:0] WIN_HI = 12'hF00;
    localparam int unsigned REV_LEGACY = 0;
    localparam int unsigned IDS_PER_BYTE = 4;
    localparam logic [7:0] TRIG_MASK = 8'hAA;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_OK  = 3'd1,
        ST_RD_BAD = 3'd2,
        ST_WR_OK  = 3'd3,
        ST_WR_BAD = 3'd4
    } itcfg_state_e;

endpackage

// File: rtl/itcfg_decode.sv
`timescale 1ns/1ps
module itcfg_decode #(
    parameter int unsigned NUM_IRQ  = 64,
    parameter int unsigned BASE_IRQ = 0,
    parameter int unsigned GRP_W    = 4
) (
    input  logic [11:0]      offset,
    output logic             in_win,
    output logic             bad,
    output logic [GRP_W-1:0] grp
);
    import itcfg_pkg::*;

    logic [11:0] rel;
    logic [31:0] first_irq;

    always_comb begin
        in_win    = (offset >= WIN_LO) && (offset < WIN_HI);
        rel       = offset - WIN_LO;
        first_irq = (32'(rel) * 32'(IDS_PER_BYTE)) + 32'(BASE_IRQ);
        bad       = in_win && (first_irq >= 32'(NUM_IRQ));
        grp       = first_irq[GRP_W+1:2];
    end

endmodule

// File: rtl/itcfg_group.sv
`timescale 1ns/1ps
module itcfg_group #(
    parameter int unsigned FIRST_ID = 0,
    parameter int unsigned NUM_SGI  = 16,
    parameter bit          LEGACY   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [3:0] edge_o,
    output logic [7:0] rdata
);
    logic [3:0] model_q;

    for (genvar i = 0; i < 4; i++) begin : g_field
        localparam bit IS_SGI = (FIRST_ID + i) < NUM_SGI;
        logic wbit_edge;

        assign wbit_edge = IS_SGI ? 1'b1 : wdata[2*i+1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                edge_o[i] <= IS_SGI;
            end else if (wr_en) begin
                edge_o[i] <= wbit_edge;
            end
        end

        if (LEGACY) begin : g_model
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    model_q[i] <= 1'b0;
                end else if (wr_en) begin
                    model_q[i] <= wdata[2*i];
                end
            end
        end else begin : g_nomodel
            assign model_q[i] = 1'b0;
        end

        assign rdata[2*i+1] = edge_o[i];
        assign rdata[2*i]   = model_q[i];
    end

endmodule

// File: rtl/itcfg_ctrl.sv
`timescale 1ns/1ps
module itcfg_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       in_win,
    input  logic       bad,
    input  logic [7:0] rd_mux,
    output logic       wr_en,
    output logic       rsp_rd_valid,
    output logic [7:0] rsp_rd_data,
    output logic       rsp_bad
);
    import itcfg_pkg::*;

    itcfg_state_e state_q, state_d;
    logic [7:0]   rd_hold;
    logic         claim;

    assign claim = req_valid && in_win;
    assign wr_en = claim && req_write && !bad;

    always_comb begin
        state_d = ST_IDLE;
        if (claim) begin
            unique case ({req_write, bad})
                2'b00:   state_d = ST_RD_OK;
                2'b01:   state_d = ST_RD_BAD;
                2'b10:   state_d = ST_WR_OK;
                default: state_d = ST_WR_BAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hold <= 8'h00;
        end else if (claim && !req_write && !bad) begin
            rd_hold <= rd_mux;
        end
    end

    always_comb begin
        rsp_rd_valid = 1'b0;
        rsp_rd_data  = 8'h00;
        rsp_bad      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RD_OK: begin
                rsp_rd_valid = 1'b1;
                rsp_rd_data  = rd_hold;
            end
            ST_RD_BAD: begin
                rsp_rd_valid = 1'b1;
                rsp_bad      = 1'b1;
            end
            ST_WR_OK: begin
            end
            ST_WR_BAD: begin
                rsp_bad = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/itcfg_bank.sv
`timescale 1ns/1ps
module itcfg_bank #(
    parameter int unsigned NUM_IRQ  = 64,
    parameter int unsigned NUM_SGI  = 16,
    parameter int unsigned BASE_IRQ = 0,
    parameter int unsigned REVISION = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [11:0]        req_offset,
    input  logic [7:0]         req_wdata,
    output logic               rsp_rd_valid,
    output logic [7:0]         rsp_rd_data,
    output logic               rsp_bad,
    output logic [NUM_IRQ-1:0] edge_mode
);
    import itcfg_pkg::*;

    localparam int unsigned NUM_GRP = NUM_IRQ / IDS_PER_BYTE;
    localparam int unsigned GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam bit          LEGACY  = (REVISION == REV_LEGACY);

    logic             in_win;
    logic             bad;
    logic [GRP_W-1:0] grp;
    logic             wr_en;
    logic [7:0]       grp_rdata [NUM_GRP];
    logic [7:0]       rd_mux;
    logic [7:0]       wdata_eff;

    itcfg_decode #(
        .NUM_IRQ (NUM_IRQ),
        .BASE_IRQ(BASE_IRQ),
        .GRP_W   (GRP_W)
    ) u_decode (
        .offset(req_offset),
        .in_win(in_win),
        .bad   (bad),
        .grp   (grp)
    );

    itcfg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .in_win      (in_win),
        .bad         (bad),
        .rd_mux      (rd_mux),
        .wr_en       (wr_en),
        .rsp_rd_valid(rsp_rd_valid),
        .rsp_rd_data (rsp_rd_data),
        .rsp_bad     (rsp_bad)
    );

    assign wdata_eff = req_wdata;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic sel;
        assign sel = wr_en && (grp == GRP_W'(g));

        itcfg_group #(
            .FIRST_ID(g * IDS_PER_BYTE),
            .NUM_SGI (NUM_SGI),
            .LEGACY  (LEGACY)
        ) u_group (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel),
            .wdata (wdata_eff),
            .edge_o(edge_mode[g*4 +: 4]),
            .rdata (grp_rdata[g])
        );
    end

    always_comb begin
        rd_mux = 8'h00;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp == GRP_W'(g)) begin
                rd_mux = grp_rdata[g];
            end
        end
    end

endmodule

// File: rtl/itcfg_bank_chk.sv
`timescale 1ns/1ps
module itcfg_bank_chk #(
    parameter int unsigned NUM_IRQ  = 64,
    parameter int unsigned NUM_SGI  = 16,
    parameter int unsigned BASE_IRQ = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_offset,
    input logic               rsp_rd_valid,
    input logic [7:0]         rsp_rd_data,
    input logic               rsp_bad,
    input logic [NUM_IRQ-1:0] edge_mode
);
    logic        c_inwin;
    logic        c_bad;
    logic [31:0] c_first;

    assign c_inwin = (req_offset >= 12'hC00) && (req_offset <= 12'hEFF);
    assign c_first = ((32'(req_offset) - 32'h0000_0C00) << 2) + 32'(BASE_IRQ);
    assign c_bad   = c_inwin && (c_first >= 32'(NUM_IRQ));

    AST_SGI_STAY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        &edge_mode[NUM_SGI-1:0]); // R4

    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd_valid |-> $past(req_valid && !req_write)); // R2

    AST_BAD_FROM_BAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad |-> $past(req_valid && c_bad)); // R8

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_bad && rsp_rd_valid) |-> (rsp_rd_data == 8'h00)); // R8

    AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && c_bad) |-> $stable(edge_mode)); // R8

    AST_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !c_inwin) |-> (!rsp_rd_valid && !rsp_bad && $stable(edge_mode))); // R9

    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_write) |-> $stable(edge_mode)); // R3

endmodule

bind itcfg_bank itcfg_bank_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_SGI (NUM_SGI),
    .BASE_IRQ(BASE_IRQ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_offset  (req_offset),
    .rsp_rd_valid(rsp_rd_valid),
    .rsp_rd_data (rsp_rd_data),
    .rsp_bad     (rsp_bad),
    .edge_mode   (edge_mode)
);

// File: tb/tb_itcfg_bank.sv
`timescale 1ns/1ps
module tb_itcfg_bank;

    localparam int unsigned NIRQ = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_offset = 12'h000;
    logic [7:0]      req_wdata = 8'h00;
    logic            rv_a, bad_a, rv_b, bad_b;
    logic [7:0]      rd_a, rd_b;
    logic [NIRQ-1:0] em_a, em_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    itcfg_bank #(.NUM_IRQ(NIRQ), .NUM_SGI(16), .BASE_IRQ(0), .REVISION(0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_rd_valid(rv_a), .rsp_rd_data(rd_a), .rsp_bad(bad_a), .edge_mode(em_a));

    itcfg_bank #(.NUM_IRQ(NIRQ), .NUM_SGI(16), .BASE_IRQ(0), .REVISION(1)) dut_nl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_rd_valid(rv_b), .rsp_rd_data(rd_b), .rsp_bad(bad_b), .edge_mode(em_b));

    typedef struct packed {
        logic        wr;
        logic [11:0] off;
        logic [7:0]  wd;
        logic        ev;
        logic [7:0]  ed;
        logic        eb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1'b0, 12'hC00, 8'h00, 1'b1, 8'hAA, 1'b0, 4'd1},  // R1 SGI reset
        '{1'b0, 12'hC04, 8'h00, 1'b1, 8'h00, 1'b0, 4'd1},  // R1 PPI reset
        '{1'b0, 12'hC03, 8'h00, 1'b1, 8'hAA, 1'b0, 4'd1},  // R1 last SGI byte
        '{1'b1, 12'hC00, 8'h55, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b0, 12'hC00, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd4},  // R4 R6
        '{1'b1, 12'hC01, 8'h00, 1'b0, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b0, 12'hC01, 8'h00, 1'b1, 8'hAA, 1'b0, 4'd4},  // R4
        '{1'b1, 12'hC04, 8'hAA, 1'b0, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b0, 12'hC04, 8'h00, 1'b1, 8'hAA, 1'b0, 4'd5},  // R5
        '{1'b1, 12'hC04, 8'h01, 1'b0, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b0, 12'hC04, 8'h00, 1'b1, 8'h01, 1'b0, 4'd6},  // R5 R6
        '{1'b1, 12'hC08, 8'hE4, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
        '{1'b0, 12'hC08, 8'h00, 1'b1, 8'hE4, 1'b0, 4'd2},  // R2 R3
        '{1'b1, 12'hC0F, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd3},  // R3
        '{1'b0, 12'hC0F, 8'h00, 1'b1, 8'h3C, 1'b0, 4'd2},  // R2 R3
        '{1'b0, 12'hC10, 8'h00, 1'b1, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b1, 12'hC10, 8'hFF, 1'b0, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b0, 12'hBFF, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 12'hF00, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},  // R9
        '{1'b1, 12'hF00, 8'hFF, 1'b0, 8'h00, 1'b0, 4'd9},  // R9
        '{1'b1, 12'hBFC, 8'hFF, 1'b0, 8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 12'hEFF, 8'h00, 1'b1, 8'h00, 1'b1, 4'd8}   // R8
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs set on a falling edge; step passes one rising edge and returns on the next falling edge
    task automatic drive(input logic w, input logic [11:0] off, input logic [7:0] d);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = off;
        req_wdata  = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_write = 1'b0;
        step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        // R1: reset state at the ports
        check("R1 edge_mode after reset", 64'(em_a), 64'h0000_0000_0000_FFFF);
        check("R1 outputs idle after reset", {61'd0, rv_a, bad_a, |rd_a}, 64'd0);

        for (int k = 0; k < NV; k++) begin
            drive(VT[k].wr, VT[k].off, VT[k].wd);
            step();
            n_chk++;
            if (rv_a !== VT[k].ev || bad_a !== VT[k].eb || (VT[k].ev && rd_a !== VT[k].ed)) begin
                n_fail++;
                $display("FAIL R%0d row %0d actual v=%b d=%h b=%b expected v=%b d=%h b=%b",
                         VT[k].req, k, rv_a, rd_a, bad_a, VT[k].ev, VT[k].ed, VT[k].eb);
            end
            idle();
        end

        // R3 R5: trigger vector after the table
        check("R3 R5 edge_mode legacy", 64'(em_a), 64'h6000_000C_0000_FFFF);
        check("R7 edge_mode non-legacy", 64'(em_b), 64'h6000_000C_0000_FFFF);

        // R7: non-legacy model bits dropped and read as 0
        drive(1'b0, 12'hC00, 8'h00); step();
        check("R7 nl read C00", {55'd0, rv_b, rd_b}, {55'd0, 1'b1, 8'hAA});
        idle();
        drive(1'b0, 12'hC04, 8'h00); step();
        check("R7 nl read C04", {55'd0, rv_b, rd_b}, {55'd0, 1'b1, 8'h00});
        idle();
        drive(1'b0, 12'hC08, 8'h00); step();
        check("R7 nl read C08", {55'd0, rv_b, rd_b}, {55'd0, 1'b1, 8'hA0});
        check("R6 legacy read C08", {55'd0, rv_a, rd_a}, {55'd0, 1'b1, 8'hE4});
        idle();

        // R10: back-to-back requests
        drive(1'b0, 12'hC0F, 8'h00); step();
        check("R10 b2b first read", {55'd0, rv_a, rd_a}, {55'd0, 1'b1, 8'h3C});
        drive(1'b1, 12'hC0C, 8'h80); step();
        check("R10 b2b write no rd", {62'd0, rv_a, bad_a}, 64'd0);
        check("R3 edge visible next cycle", 64'(em_a[51:48]), 64'h8);
        drive(1'b0, 12'hC0C, 8'h00); step();
        check("R10 b2b read back", {55'd0, rv_a, rd_a}, {55'd0, 1'b1, 8'h80});
        idle();
        // R2: one-cycle response pulse
        check("R2 pulse ends", {62'd0, rv_a, bad_a}, 64'd0);

        // R8: bad pulse is one cycle
        drive(1'b0, 12'hD00, 8'h00); step();
        check("R8 bad read", {54'd0, rv_a, bad_a, rd_a}, {54'd0, 1'b1, 1'b1, 8'h00});
        idle();
        check("R8 bad pulse ends", {63'd0, bad_a}, 64'd0);

        // R1: second reset restores defaults
        do_reset();
        check("R1 edge_mode after second reset", 64'(em_a), 64'h0000_0000_0000_FFFF);
        drive(1'b0, 12'hC00, 8'h00); step();
        check("R1 read C00 after reset", {55'd0, rv_a, rd_a}, {55'd0, 1'b1, 8'hAA});
        idle();
        drive(1'b0, 12'hC08, 8'h00); step();
        check("R1 read C08 after reset", {55'd0, rv_a, rd_a}, {55'd0, 1'b1, 8'h00});
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule